// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time on behalf of a processor port. A request names an operation (exchange, test-and-set, fetch-and-add or compare-and-swap), a byte address, an operand and an expected value. Before it touches memory, the unit asks a coherence agent for exclusive ownership of the cache line that holds the address. It then reads the word, computes the new value and writes it back while it still holds that ownership.

If the coherence agent signals that the line was taken away during the read cycle or the write cycle, the unit throws away the partial result. No write takes place, and the unit asks for ownership again. On completion it pulses a done strobe. It also returns the old memory word and a flag. For compare-and-swap the flag shows success. For the other operations it shows that the old word was zero, which is how a lock acquire with test-and-set is judged. Plain loads and stores from the port that hit the busy line are held off until the operation ends.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Opcode 0 (exchange) returns the old word on `rsp_old` and leaves the operand in memory; `rsp_zf` is 1 exactly when the old word was zero.
- R2: Opcode 1 (test-and-set) always leaves 1 in memory and returns the old word; `rsp_zf` is 1 exactly when the old word was zero (lock acquired).
- R3: Opcode 2 (fetch-and-add) returns the old word and leaves old plus operand, wrapping modulo 2^32; `rsp_zf` is 1 exactly when the old word was zero.
- R4: Opcode 3 (compare-and-swap) writes the operand only when memory equals the expected value; `rsp_zf` is 1 on success and 0 on failure, and on failure memory is unchanged.
- R5: No memory read happens before `own_grant` is seen with `own_req` high, and `own_req` stays high with no memory access for as long as the grant is withheld; `req_ready` is low meanwhile.
- R6: When `own_lost` is high during the read cycle or the write cycle, no write happens in that cycle and the unit raises `own_req` again in the next cycle; the operation then completes exactly once, with exactly one memory write.
- R7: `rsp_done` is a one-cycle pulse; `rsp_old` and `rsp_zf` change only in the cycle `rsp_done` is high.
- R8: While an operation is in progress, `plain_stall` is 1 for a plain access whose address lies in the same 64-byte line as the atomic address, and 0 for an access to another line or when the unit is idle.
- R9: After reset `req_ready` is 1, and `own_req`, `rsp_done`, `mem_rd_en`, `mem_wr_en` and `plain_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New atomic request present |
| req_op | input | 2 | Operation: 0 exchange, 1 test-and-set, 2 fetch-and-add, 3 compare-and-swap |
| req_addr | input | 16 | Byte address of the target word |
| req_operand | input | 32 | Register value / addend / new value |
| req_expect | input | 32 | Expected value for compare-and-swap |
| req_ready | output | 1 | Unit idle; a request is taken this cycle |
| own_req | output | 1 | Asking for exclusive ownership of the line |
| own_addr | output | 16 | Address whose line is requested |
| own_grant | input | 1 | Line is now held exclusively |
| own_lost | input | 1 | Line was invalidated by another agent |
| mem_rd_en | output | 1 | Read the target word this cycle |
| mem_wr_en | output | 1 | Write the target word this cycle |
| mem_addr | output | 16 | Word address for the access |
| mem_wdata | output | 32 | Value to write |
| mem_rdata | input | 32 | Word returned in the read cycle |
| plain_valid | input | 1 | A plain load/store wants to issue |
| plain_addr | input | 16 | Address of that plain access |
| plain_stall | output | 1 | Plain access must wait |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_old | output | 32 | Old memory word of the last operation |
| rsp_zf | output | 1 | Success / old-was-zero flag |

## Verification
The two functions that can meet in one cycle are the commit write and the loss of line ownership: an invalidation may arrive in the very cycle the unit writes back. The bench raises `own_lost` once in the read cycle and once in the write cycle of a fetch-and-add. It judges the outcome by the final memory word, which must show the addend applied exactly once, by the count of memory writes and grants, and by the returned old value. The plain-access hold-off is also exercised while a grant is withheld, with addresses inside and outside the busy line.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

    typedef enum logic [1:0] {
        OP_XCHG = 2'd0,
        OP_TAS  = 2'd1,
        OP_FADD = 2'd2,
        OP_CAS  = 2'd3
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } rmw_st_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  rmw_op_e         op,
    input  logic [DW-1:0]   old_val,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   expect_val,
    output logic [DW-1:0]   new_val,
    output logic            do_write,
    output logic            flag
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic old_zero;
    logic match;

    always_comb begin
        old_zero = (old_val == '0);
        match    = (old_val == expect_val);
        new_val  = old_val;
        do_write = 1'b1;
        flag     = old_zero;
        case (op)
            OP_XCHG: new_val = operand;
            OP_TAS:  new_val = ONE;
            OP_FADD: new_val = old_val + operand;
            OP_CAS: begin
                new_val  = operand;
                do_write = match;
                flag     = match;
            end
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/rmw_line_guard.sv
module rmw_line_guard #(
    parameter int AW  = 16,
    parameter int OFF = 6
) (
    input  logic          busy,
    input  logic [AW-1:0] atom_addr,
    input  logic          plain_valid,
    input  logic [AW-1:0] plain_addr,
    output logic          plain_stall
);

    localparam int TAGW = AW - OFF;

    logic [TAGW-1:0] atom_line;
    logic [TAGW-1:0] plain_line;

    always_comb begin
        atom_line   = atom_addr[AW-1:OFF];
        plain_line  = plain_addr[AW-1:OFF];
        plain_stall = busy && plain_valid && (atom_line == plain_line);
    end

endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_operand,
    input  logic [DW-1:0]   req_expect,
    output logic            req_ready,
    output logic            own_req,
    input  logic            own_grant,
    input  logic            own_lost,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [AW-1:0]   cur_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW-1:0]   alu_new,
    input  logic            alu_wr,
    input  logic            alu_flag,
    output rmw_op_e         cur_op,
    output logic [DW-1:0]   cur_operand,
    output logic [DW-1:0]   cur_expect,
    output logic            busy,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_old,
    output logic            rsp_zf
);

    typedef struct packed {
        rmw_st_e       st;
        rmw_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] operand;
        logic [DW-1:0] expv;
        logic [DW-1:0] wdata;
        logic          wr;
        logic [DW-1:0] old_pend;
        logic          flag_pend;
        logic [DW-1:0] rsp_old;
        logic          rsp_zf;
        logic          done;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.op      = rmw_op_e'(req_op);
                    s_d.addr    = req_addr;
                    s_d.operand = req_operand;
                    s_d.expv    = req_expect;
                    s_d.st      = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (own_grant) begin
                    s_d.st = ST_READ;
                end
            end
            ST_READ: begin
                if (own_lost) begin
                    s_d.st = ST_ACQ;
                end else begin
                    s_d.old_pend  = mem_rdata;
                    s_d.wdata     = alu_new;
                    s_d.wr        = alu_wr;
                    s_d.flag_pend = alu_flag;
                    s_d.st        = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (own_lost) begin
                    s_d.st = ST_ACQ;
                end else begin
                    s_d.rsp_old = s_q.old_pend;
                    s_d.rsp_zf  = s_q.flag_pend;
                    s_d.done    = 1'b1;
                    s_d.st      = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready   = (s_q.st == ST_IDLE);
        own_req     = (s_q.st == ST_ACQ);
        mem_rd_en   = (s_q.st == ST_READ);
        mem_wr_en   = (s_q.st == ST_WRITE) && s_q.wr && !own_lost;
        mem_wdata   = s_q.wdata;
        cur_addr    = s_q.addr;
        cur_op      = s_q.op;
        cur_operand = s_q.operand;
        cur_expect  = s_q.expv;
        busy        = (s_q.st != ST_IDLE);
        rsp_done    = s_q.done;
        rsp_old     = s_q.rsp_old;
        rsp_zf      = s_q.rsp_zf;
    end

    AST_READ_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> $past(own_grant)); // R5

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en)); // R5

    AST_LOST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (own_lost && (mem_rd_en || busy && !own_req && !mem_rd_en)) |=> own_req); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R7

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> ($stable(rsp_old) && $stable(rsp_zf))); // R7

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 16,
    parameter int LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_operand,
    input  logic [DW-1:0] req_expect,
    output logic          req_ready,
    output logic          own_req,
    output logic [AW-1:0] own_addr,
    input  logic          own_grant,
    input  logic          own_lost,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          plain_valid,
    input  logic [AW-1:0] plain_addr,
    output logic          plain_stall,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_old,
    output logic          rsp_zf
);

    localparam int OFF = $clog2(LINE_BYTES);

    rmw_op_e       cur_op;
    logic [DW-1:0] cur_operand;
    logic [DW-1:0] cur_expect;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] alu_new;
    logic          alu_wr;
    logic          alu_flag;
    logic          busy;

    rmw_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_operand (req_operand),
        .req_expect  (req_expect),
        .req_ready   (req_ready),
        .own_req     (own_req),
        .own_grant   (own_grant),
        .own_lost    (own_lost),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .cur_addr    (cur_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .alu_new     (alu_new),
        .alu_wr      (alu_wr),
        .alu_flag    (alu_flag),
        .cur_op      (cur_op),
        .cur_operand (cur_operand),
        .cur_expect  (cur_expect),
        .busy        (busy),
        .rsp_done    (rsp_done),
        .rsp_old     (rsp_old),
        .rsp_zf      (rsp_zf)
    );

    rmw_alu #(.DW(DW)) u_alu (
        .op         (cur_op),
        .old_val    (mem_rdata),
        .operand    (cur_operand),
        .expect_val (cur_expect),
        .new_val    (alu_new),
        .do_write   (alu_wr),
        .flag       (alu_flag)
    );

    rmw_line_guard #(.AW(AW), .OFF(OFF)) u_guard (
        .busy        (busy),
        .atom_addr   (cur_addr),
        .plain_valid (plain_valid),
        .plain_addr  (plain_addr),
        .plain_stall (plain_stall)
    );

    assign own_addr = cur_addr;
    assign mem_addr = cur_addr;

    AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        plain_stall |-> !req_ready); // R8

endmodule

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;

    localparam int NV = 9;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  idx;
        logic [31:0] opnd;
        logic [31:0] expv;
        logic [31:0] old;
        logic        flag;
        logic [31:0] mem;
    } vec_t;

    // R1 exchange, R2 test-and-set, R3 fetch-and-add, R4 compare-and-swap
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd1, 32'h0000AAAA, 32'h0, 32'h5,        1'b0, 32'h0000AAAA}, // R1
        '{2'd0, 4'd0, 32'h7,        32'h0, 32'h0,        1'b1, 32'h7},        // R1
        '{2'd1, 4'd0, 32'h0,        32'h0, 32'h7,        1'b0, 32'h1},        // R2
        '{2'd1, 4'd4, 32'h0,        32'h0, 32'h0,        1'b1, 32'h1},        // R2
        '{2'd2, 4'd2, 32'h1,        32'h0, 32'hFFFFFFFF, 1'b0, 32'h0},        // R3
        '{2'd2, 4'd3, 32'd23,       32'h0, 32'd100,      1'b0, 32'd123},      // R3
        '{2'd3, 4'd3, 32'd9,        32'd123, 32'd123,    1'b1, 32'd9},        // R4
        '{2'd3, 4'd3, 32'd50,       32'd123, 32'd9,      1'b0, 32'd9},        // R4
        '{2'd3, 4'd2, 32'h1234,     32'h0, 32'h0,        1'b1, 32'h1234}      // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_operand = '0;
    logic [31:0] req_expect = '0;
    logic        req_ready;
    logic        own_req;
    logic [15:0] own_addr;
    logic        own_grant = 1'b0;
    logic        own_lost = 1'b0;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        plain_valid = 1'b0;
    logic [15:0] plain_addr = '0;
    logic        plain_stall;
    logic        rsp_done;
    logic [31:0] rsp_old;
    logic        rsp_zf;

    logic [31:0] mem [16];
    logic        grant_en = 1'b1;
    int          wr_cnt = 0;
    int          grant_cnt = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    atomic_rmw_unit uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_operand(req_operand), .req_expect(req_expect), .req_ready(req_ready),
        .own_req(own_req), .own_addr(own_addr), .own_grant(own_grant), .own_lost(own_lost),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .plain_valid(plain_valid), .plain_addr(plain_addr), .plain_stall(plain_stall),
        .rsp_done(rsp_done), .rsp_old(rsp_old), .rsp_zf(rsp_zf)
    );

    assign mem_rdata = mem[mem_addr[9:6]];

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr[9:6]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (own_grant && own_req) grant_cnt <= grant_cnt + 1;
    end

    always @(negedge clk) own_grant <= own_req && grant_en;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] idx,
                         input logic [31:0] opnd, input logic [31:0] expv);
        @(negedge clk);
        req_valid   = 1'b1;
        req_op      = op;
        req_addr    = {6'd0, idx, 6'd4};
        req_operand = opnd;
        req_expect  = expv;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            if (rsp_done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[1] = 32'h5;
        mem[2] = 32'hFFFFFFFF;
        mem[3] = 32'd100;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 req_ready", {31'd0, req_ready}, 32'd1);
        check({own_req, rsp_done, mem_rd_en, mem_wr_en, plain_stall} == 5'b0,
              "R9 outputs idle", {27'd0, own_req, rsp_done, mem_rd_en, mem_wr_en, plain_stall}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            int w0;
            w0 = wr_cnt;
            issue(VECS[v].op, VECS[v].idx, VECS[v].opnd, VECS[v].expv);
            wait_done();
            check(rsp_done == 1'b1, "R7 done seen", {31'd0, rsp_done}, 32'd1);
            check(rsp_old == VECS[v].old, "R1-4 old value", rsp_old, VECS[v].old);
            check(rsp_zf == VECS[v].flag, "R1-4 flag", {31'd0, rsp_zf}, {31'd0, VECS[v].flag});
            @(negedge clk);
            check(rsp_done == 1'b0, "R7 done one cycle", {31'd0, rsp_done}, 32'd0);
            check(mem[VECS[v].idx] == VECS[v].mem, "R1-4 memory", mem[VECS[v].idx], VECS[v].mem);
            if (VECS[v].op == 2'd3 && !VECS[v].flag)
                check(wr_cnt == w0, "R4 no write on failure", wr_cnt, w0);
            check(rsp_old == VECS[v].old, "R7 result held", rsp_old, VECS[v].old);
        end

        // R5 and R8: grant withheld, plain accesses probed
        grant_en = 1'b0;
        issue(2'd2, 4'd5, 32'd3, 32'd0);
        repeat (4) @(negedge clk);
        check(own_req == 1'b1, "R5 own_req held", {31'd0, own_req}, 32'd1);
        check(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R5 no access", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
        check(req_ready == 1'b0, "R5 not ready", {31'd0, req_ready}, 32'd0);
        plain_valid = 1'b1;
        plain_addr  = {6'd0, 4'd5, 6'd60};
        #0.1;
        check(plain_stall == 1'b1, "R8 same line stalled", {31'd0, plain_stall}, 32'd1);
        plain_addr  = {6'd0, 4'd6, 6'd4};
        #0.1;
        check(plain_stall == 1'b0, "R8 other line free", {31'd0, plain_stall}, 32'd0);
        grant_en = 1'b1;
        wait_done();
        check(rsp_old == 32'd0 && rsp_zf == 1'b1, "R3 after wait", rsp_old, 32'd0);
        @(negedge clk);
        check(mem[5] == 32'd3, "R3 mem after wait", mem[5], 32'd3);
        plain_addr = {6'd0, 4'd5, 6'd4};
        #0.1;
        check(plain_stall == 1'b0, "R8 idle no stall", {31'd0, plain_stall}, 32'd0);
        plain_valid = 1'b0;

        // R6: ownership lost in the read cycle
        begin
            int w0, g0;
            w0 = wr_cnt; g0 = grant_cnt;
            issue(2'd2, 4'd3, 32'd1, 32'd0);
            for (int k = 0; k < 50 && !mem_rd_en; k++) @(negedge clk);
            own_lost = 1'b1;
            @(negedge clk);
            own_lost = 1'b0;
            check(own_req == 1'b1, "R6 re-request after read loss", {31'd0, own_req}, 32'd1);
            wait_done();
            check(rsp_old == 32'd9, "R6 old after read loss", rsp_old, 32'd9);
            @(negedge clk);
            check(mem[3] == 32'd10, "R6 added once (read loss)", mem[3], 32'd10);
            check(wr_cnt - w0 == 1, "R6 one write (read loss)", wr_cnt - w0, 32'd1);
            check(grant_cnt - g0 == 2, "R6 two grants (read loss)", grant_cnt - g0, 32'd2);
        end

        // R6: ownership lost in the same cycle as the commit write
        begin
            int w0, g0;
            w0 = wr_cnt; g0 = grant_cnt;
            issue(2'd2, 4'd3, 32'd1, 32'd0);
            for (int k = 0; k < 50 && !mem_wr_en; k++) @(negedge clk);
            own_lost = 1'b1;
            #0.1;
            check(mem_wr_en == 1'b0, "R6 write blocked", {31'd0, mem_wr_en}, 32'd0);
            @(negedge clk);
            own_lost = 1'b0;
            check(own_req == 1'b1, "R6 re-request after write loss", {31'd0, own_req}, 32'd1);
            wait_done();
            check(rsp_old == 32'd10, "R6 old after write loss", rsp_old, 32'd10);
            @(negedge clk);
            check(mem[3] == 32'd11, "R6 added once (write loss)", mem[3], 32'd11);
            check(wr_cnt - w0 == 1, "R6 one write (write loss)", wr_cnt - w0, 32'd1);
            check(grant_cnt - g0 == 2, "R6 two grants (write loss)", grant_cnt - g0, 32'd2);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule